// File: doc/BRIEF.md
# Dual-Channel Periodic Interval Timer

This block holds two independent 16-bit down-counters, called channel 0 and channel 2, that are driven by an external enable pulse at a fixed counting rate of 1,193,180 pulses per second. Software configures a channel by writing a control byte to the shared control port. It loads the reload value with two byte writes to that channel's data port, low byte first. When the second byte arrives, the channel starts counting. After as many counting pulses as the loaded value, it raises a one-cycle fire pulse and sets its expiry status. It then reloads itself and keeps running for periodic operation.

All writes go through a single byte-wide write port. A two-bit port code picks the target, and a status byte for either channel can be read combinationally. Control bytes that ask for anything other than low-then-high access, that select channel 1, or that carry the read-back selector are refused, and the error output pulses. There is only one byte-pending flag, and both data ports share it. If a low byte goes to one channel and a high byte to the other, the second channel is loaded with both bytes.

Top module: `pit_timer`

## Requirements
- R1: After reset, both status bytes read 0x00, no fire pulse occurs, `cfg_err` is 0 and both mode outputs are 0.
- R2: A write to the control port (port code 3) whose bits 5:4 are not both 1 pulses `cfg_err` in the following cycle and leaves both modes unchanged.
- R3: A control byte whose bits 7:6 equal 1 or 3 (read-back) pulses `cfg_err` in the following cycle and changes no mode.
- R4: A valid control byte (bits 5:4 = 11, bits 7:6 = 0 or 2) stores its bits 3:1 as the mode of channel 0 (bits 7:6 = 0) or channel 2 (bits 7:6 = 2) without raising `cfg_err`; no other write changes a mode.
- R5: A lone data write (port code 0 or 2) only stores the low byte and sets the pending flag. The addressed channel does not start until a second data write supplies the high byte.
- R6: The pending flag is shared by both channels. A low byte written to port 0, followed by a high byte written to port 2, loads channel 2 with the 16-bit value and leaves channel 0 untouched.
- R7: After a load of N, the channel's fire output pulses for one cycle in the clock after the N-th `tick_en` pulse. From then on, its status byte reads 0x20 (bit 5 set).
- R8: A running channel reloads on expiry and fires again after every further N `tick_en` pulses.
- R9: A loaded value of 0 counts as 65536 pulses.
- R10: Loading a channel clears its status to 0x00 until its next expiry.
- R11: A channel only counts in cycles where `tick_en` is 1, and a channel that was never loaded never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle counting-rate enable pulse |
| wr_en | input | 1 | Write strobe |
| wr_port | input | 2 | Target: 0 channel 0 data, 2 channel 2 data, 3 control, 1 unused |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Status select: 0 channel 0, 1 channel 2 |
| rd_status | output | 8 | Status byte of the selected channel |
| cfg_err | output | 1 | One-cycle pulse on a refused control byte |
| mode_c0 | output | 3 | Stored mode of channel 0 |
| mode_c2 | output | 3 | Stored mode of channel 2 |
| fire_c0 | output | 1 | Expiry pulse of channel 0 |
| fire_c2 | output | 1 | Expiry pulse of channel 2 |

## Verification
The bench checks the exact pulse on which a channel fires, both on the first period and on later periods. A counter that is off by one would fire one tick early or late, and a counter that does not reload would stop after the first fire. It loads zero and expects silence through 65535 ticks and a fire on the next one; a design that treats zero literally would fire at once or never. It splits a load across the two data ports. A design with one pending flag per channel would leave channel 2 waiting and never fire. It also sends a lone low byte, then refused control bytes, and expects no start and no mode change. A design that starts on the first byte, or that stores the mode of a refused control byte, would fail those checks.

// File: rtl/pit_pkg.sv
// Shared constants for the dual-channel interval timer.
package pit_pkg;
    localparam logic [1:0] PORT_C0   = 2'd0;
    localparam logic [1:0] PORT_C2   = 2'd2;
    localparam logic [1:0] PORT_CTRL = 2'd3;
    localparam logic [7:0] STATUS_EXPIRED = 8'h20;
    localparam int unsigned NUM_CH = 2;

    typedef enum logic [1:0] {
        SEL_CH0      = 2'd0,
        SEL_CH1      = 2'd1,
        SEL_CH2      = 2'd2,
        SEL_READBACK = 2'd3
    } ch_sel_e;
endpackage

// File: rtl/pit_ctrl_decode.sv
// Control-byte decoder: accepts low-then-high access for channels 0 and 2,
// stores the 3-bit mode, and pulses an error for every other control byte.
// Assumes ctrl_wr is a single-cycle strobe.
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_byte,
    output logic [MODE_W-1:0] mode0,
    output logic [MODE_W-1:0] mode2,
    output logic              err
);
    ch_sel_e    sel;
    logic       access_ok;
    logic       sel_ok;

    // Field extraction from the control byte.
    always_comb begin
        sel       = ch_sel_e'(ctrl_byte[7:6]);
        access_ok = (ctrl_byte[5:4] == 2'b11);
        sel_ok    = (sel == SEL_CH0) || (sel == SEL_CH2);
    end

    // Mode storage and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode0 <= '0;
            mode2 <= '0;
            err   <= 1'b0;
        end else begin
            err <= 1'b0;
            if (ctrl_wr) begin
                if (!access_ok || !sel_ok) begin
                    err <= 1'b1;
                end else if (sel == SEL_CH0) begin
                    mode0 <= ctrl_byte[MODE_W:1];
                end else begin
                    mode2 <= ctrl_byte[MODE_W:1];
                end
            end
        end
    end
endmodule

// File: rtl/pit_byte_collect.sv
// Two-write value assembler with one pending flag shared by all data ports.
// The first write keeps the low byte. The second write issues a load strobe,
// in the same cycle, to the channel named by the second write's port.
module pit_byte_collect
    import pit_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_wr,
    input  logic [1:0]         data_port,
    input  logic [7:0]         data_byte,
    output logic [NUM_CH-1:0]  load,
    output logic [COUNT_W-1:0] load_val
);
    logic       pending;
    logic [7:0] low_q;
    logic       complete;

    // Load strobe and assembled value.
    always_comb begin
        complete = data_wr && pending;
        load_val = {data_byte, low_q};
        load[0]  = complete && (data_port == PORT_C0);
        load[1]  = complete && (data_port == PORT_C2);
    end

    // Pending flag and low-byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            low_q   <= '0;
        end else if (data_wr) begin
            if (pending) begin
                pending <= 1'b0;
            end else begin
                pending <= 1'b1;
                low_q   <= data_byte;
            end
        end
    end
endmodule

// File: rtl/pit_chan.sv
// One periodic down-counter. A load arms it and clears its expiry status.
// Each tick_en decrements it. On the last tick it fires, sets the sticky
// status and reloads. A loaded 0 counts as 2**COUNT_W. Load wins over a tick.
module pit_chan #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    output logic               fire,
    output logic               expired
);
    localparam int CNT_W = COUNT_W + 1;
    localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(1) << COUNT_W;

    logic [COUNT_W-1:0] reload_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               running;

    // Widen a stored value so that zero becomes the full range.
    function automatic logic [CNT_W-1:0] widen(input logic [COUNT_W-1:0] v);
        return (v == '0) ? FULL_COUNT : {1'b0, v};
    endfunction

    // Count, reload and expiry tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            running  <= 1'b0;
            expired  <= 1'b0;
            fire     <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                reload_q <= load_val;
                cnt_q    <= widen(load_val);
                running  <= 1'b1;
                expired  <= 1'b0;
            end else if (running && tick_en) begin
                if (cnt_q == CNT_W'(1)) begin
                    cnt_q   <= widen(reload_q);
                    expired <= 1'b1;
                    fire    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pit_timer.sv
// Top of the dual-channel interval timer: routes the shared write port to
// the control decoder and the byte collector, runs one counter per channel,
// and muxes the selected channel's status byte. Channel index 1 is channel 2.
module pit_timer
    import pit_pkg::*;
#(
    parameter int COUNT_W = 16,
    parameter int MODE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_port,
    input  logic [7:0]        wr_data,
    input  logic              rd_sel,
    output logic [7:0]        rd_status,
    output logic              cfg_err,
    output logic [MODE_W-1:0] mode_c0,
    output logic [MODE_W-1:0] mode_c2,
    output logic              fire_c0,
    output logic              fire_c2
);
    logic               ctrl_wr;
    logic               data_wr;
    logic [NUM_CH-1:0]  ch_load;
    logic [NUM_CH-1:0]  ch_fire;
    logic [NUM_CH-1:0]  ch_exp;
    logic [COUNT_W-1:0] load_val;

    // Write-port routing.
    always_comb begin
        ctrl_wr = wr_en && (wr_port == PORT_CTRL);
        data_wr = wr_en && ((wr_port == PORT_C0) || (wr_port == PORT_C2));
    end

    pit_ctrl_decode #(.MODE_W(MODE_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_byte (wr_data),
        .mode0     (mode_c0),
        .mode2     (mode_c2),
        .err       (cfg_err)
    );

    pit_byte_collect #(.COUNT_W(COUNT_W)) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .data_port (wr_port),
        .data_byte (wr_data),
        .load      (ch_load),
        .load_val  (load_val)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pit_chan #(.COUNT_W(COUNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .load     (ch_load[g]),
            .load_val (load_val),
            .fire     (ch_fire[g]),
            .expired  (ch_exp[g])
        );
    end

    // Output mapping and status mux.
    always_comb begin
        fire_c0   = ch_fire[0];
        fire_c2   = ch_fire[1];
        rd_status = ch_exp[rd_sel] ? STATUS_EXPIRED : 8'h00;
    end
endmodule

// File: rtl/pit_timer_chk.sv
// Property checker for pit_timer, attached by bind below.
module pit_timer_chk #(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [1:0]        wr_port,
    input logic [7:0]        wr_data,
    input logic              rd_sel,
    input logic [7:0]        rd_status,
    input logic              cfg_err,
    input logic [MODE_W-1:0] mode_c0,
    input logic [MODE_W-1:0] mode_c2,
    input logic              fire_c0,
    input logic              fire_c2
);
    // R2
    bad_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_port == 2'd3 && wr_data[5:4] != 2'b11) |=> cfg_err);

    // R3
    readback_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_port == 2'd3 && wr_data[7:6] == 2'd3) |=> cfg_err);

    // R2
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(wr_en && wr_port == 2'd3));

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_port == 2'd3) |=> ($stable(mode_c0) && $stable(mode_c2)));

    // R7
    fire_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c0 && !rd_sel) |-> rd_status == 8'h20);

    // R11
    fire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c0 || fire_c2) |-> $past(tick_en));
endmodule

bind pit_timer pit_timer_chk #(.MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_port   (wr_port),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_status (rd_status),
    .cfg_err   (cfg_err),
    .mode_c0   (mode_c0),
    .mode_c2   (mode_c2),
    .fire_c0   (fire_c0),
    .fire_c2   (fire_c2)
);

// File: tb/tb_pit_timer.sv
// Directed bench for pit_timer: one task per scenario, each checks itself.
module tb_pit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_port = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_status;
    logic       cfg_err;
    logic [2:0] mode_c0;
    logic [2:0] mode_c2;
    logic       fire_c0;
    logic       fire_c2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pit_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_port(wr_port), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_status(rd_status), .cfg_err(cfg_err), .mode_c0(mode_c0),
        .mode_c2(mode_c2), .fire_c0(fire_c0), .fire_c2(fire_c2)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] port, input logic [7:0] data);
        wr_en = 1'b1; wr_port = port; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n, output int f0, output int f2);
        f0 = 0; f2 = 0;
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            if (fire_c0) f0++;
            if (fire_c2) f2++;
        end
    endtask

    function automatic int status_of(input logic sel);
        rd_sel = sel;
        return 0;
    endfunction

    task automatic read_status(input logic sel, output int v);
        rd_sel = sel;
        #1 v = rd_status;
    endtask

    task automatic t_reset();
        int s0, s2;
        do_reset();
        read_status(1'b0, s0);
        read_status(1'b1, s2);
        check("R1 status c0", s0, 8'h00);
        check("R1 status c2", s2, 8'h00);
        check("R1 err", cfg_err, 0);
        check("R1 mode c0", mode_c0, 0);
        check("R1 mode c2", mode_c2, 0);
        check("R1 fire", fire_c0 | fire_c2, 0);
    endtask

    task automatic t_idle();
        int f0, f2;
        ticks(10, f0, f2);
        check("R11 never-loaded c0 fires", f0, 0);
        check("R11 never-loaded c2 fires", f2, 0);
    endtask

    task automatic t_modes();
        wr(2'd3, 8'h36);
        check("R4 err after valid c0", cfg_err, 0);
        check("R4 mode c0", mode_c0, 3);
        wr(2'd3, 8'hB4);
        check("R4 err after valid c2", cfg_err, 0);
        check("R4 mode c2", mode_c2, 2);
        check("R4 mode c0 kept", mode_c0, 3);
    endtask

    task automatic t_bad_access();
        wr(2'd3, 8'h1A);
        check("R2 err on access 01", cfg_err, 1);
        check("R2 mode c0 kept", mode_c0, 3);
        wr(2'd3, 8'h8E);
        check("R2 err on access 00", cfg_err, 1);
        check("R2 mode c2 kept", mode_c2, 2);
    endtask

    task automatic t_readback();
        wr(2'd3, 8'hFE);
        check("R3 err on read-back", cfg_err, 1);
        check("R3 mode c0 kept", mode_c0, 3);
        check("R3 mode c2 kept", mode_c2, 2);
        wr(2'd3, 8'h7C);
        check("R3 err on channel 1", cfg_err, 1);
        check("R3 mode c0 kept ch1", mode_c0, 3);
    endtask

    task automatic t_single_byte();
        int f0, f2, s;
        do_reset();
        wr(2'd2, 8'h02);
        ticks(10, f0, f2);
        read_status(1'b1, s);
        check("R5 no start after low byte", f2, 0);
        check("R5 status after low byte", s, 8'h00);
        wr(2'd2, 8'h00);
        ticks(2, f0, f2);
        check("R5 start after high byte", f2, 1);
    endtask

    task automatic t_shared();
        int f0, f2;
        do_reset();
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h00);
        ticks(4, f0, f2);
        check("R6 c2 early", f2, 0);
        ticks(1, f0, f2);
        check("R6 c2 fires at 5", f2, 1);
        check("R6 c0 untouched", f0, 0);
    endtask

    task automatic t_expiry_status();
        int f0, f2, s;
        do_reset();
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h00);
        read_status(1'b0, s);
        check("R10 status after load", s, 8'h00);
        ticks(2, f0, f2);
        read_status(1'b0, s);
        check("R7 no fire before N", f0, 0);
        check("R10 status before expiry", s, 8'h00);
        ticks(1, f0, f2);
        read_status(1'b0, s);
        check("R7 fire on N-th tick", f0, 1);
        check("R7 status after expiry", s, 8'h20);
        @(negedge clk);
        check("R7 fire lasts one cycle", fire_c0, 0);
        wr(2'd0, 8'h04);
        wr(2'd0, 8'h00);
        read_status(1'b0, s);
        check("R10 reload clears status", s, 8'h00);
    endtask

    task automatic t_periodic();
        int f0, f2;
        do_reset();
        wr(2'd2, 8'h04);
        wr(2'd2, 8'h00);
        ticks(12, f0, f2);
        check("R8 three periods", f2, 3);
        ticks(3, f0, f2);
        check("R8 no fire mid-period", f2, 0);
        ticks(1, f0, f2);
        check("R8 fourth fire", f2, 1);
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R11 idle cycles no fire", fire_c2, 0);
        ticks(4, f0, f2);
        check("R11 count held without tick", f2, 1);
    endtask

    task automatic t_zero();
        int f0, f2;
        do_reset();
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        ticks(65535, f0, f2);
        check("R9 zero not early", f0, 0);
        ticks(1, f0, f2);
        check("R9 zero fires at 65536", f0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_modes();
        t_bad_access();
        t_readback();
        t_single_byte();
        t_shared();
        t_expiry_status();
        t_periodic();
        t_zero();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule